// File: doc/BRIEF.md
# DMA Data-Phase Splitter

The block turns one DMA request into the data phases a bus master puts on a PCI bus. The request is a start byte address and a byte count. When the start address is not on a bus-word boundary, the first phase carries only the bytes that reach the next boundary. Every phase after that moves a whole bus word. When a remainder is left, the final phase moves only those bytes. The bus word is a dword on a 32-bit bus and a qword on a 64-bit bus, and `BUS_W` selects which.

For each phase the block presents three things: a word-aligned address, a set of active-low byte-lane enables, and a flag that marks the final phase. It holds these values until the surrounding bus engine reports that the phase is complete, then moves on to the next phase. Addresses only ever increase in a straight line. Arbitration, the bus handshake and moving the data are handled by other logic.

Top module: `dma_phase_splitter`

## Requirements
- R1: While reset is held, and on the cycle after it is released, `phase_valid`, `phase_last` and `done` are 0 and every bit of `phase_be_n` is 1.
- R2: The first phase enables byte lanes starting at the start offset, which is `start_addr` modulo the bus-word byte count. The enabled lanes continue up to the bus-word boundary or until the count is used up, whichever comes first. Lane k is enabled by driving `phase_be_n[k]` low, and lane 0 is the lowest-addressed byte (data bits 7:0).
- R3: Every phase that is neither the first nor the final one enables all lanes: 4 on a 32-bit bus, 8 on a 64-bit bus.
- R4: The final phase enables lanes 0 upward, only as many as the bytes still left, and it has `phase_last` = 1. No earlier phase has `phase_last` = 1.
- R5: When the count fits inside the start word, exactly one phase is issued. Its enabled lanes run from the start offset for `byte_cnt` bytes, and it has `phase_last` = 1.
- R6: A start with `byte_cnt` = 0 issues no phase, and `done` is 1 on the cycle after the start.
- R7: `phase_addr` is the start address rounded down to a bus-word boundary. Its low log2(BUS_W/8) bits are always 0, and it grows by BUS_W/8 with each completed phase.
- R8: While `phase_valid` is 1 and `phase_ack` is 0, the address, enables and final-phase flag hold their values, and `phase_valid` stays 1.
- R9: `done` is a one-cycle pulse on the cycle after the final phase is acknowledged. On that same cycle `phase_valid` returns to 0.
- R10: A `start` that arrives while a transfer is in progress is ignored. The phases already in progress continue unchanged.
- R11: When a start has a non-zero count, `phase_valid` becomes 1 on the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse; accepted only when idle |
| start_addr | input | ADDR_W | Start byte address |
| byte_cnt | input | CNT_W | Number of bytes to move |
| phase_ack | input | 1 | Current phase has completed |
| phase_valid | output | 1 | A phase is being presented |
| phase_addr | output | ADDR_W | Bus-word-aligned phase address |
| phase_be_n | output | BUS_W/8 | Active-low byte-lane enables |
| phase_last | output | 1 | Marks the final phase |
| done | output | 1 | One-cycle pulse when the transfer has finished |

## Verification
The bench builds two copies of the block, one with `BUS_W` = 64 and one with `BUS_W` = 32, both with 32-bit addresses and 16-bit counts. The two widths lead to different boundary arithmetic. On the 64-bit copy, offsets of 3, 5 and 6 exercise the upper lanes 4 to 7 and a leading gap that is wider than a dword. On the 32-bit copy, a three-phase transfer has a one-byte offset and a two-byte tail. Directed transfers cover these cases:
- aligned starts
- counts that end inside the start word
- counts that exactly fill the start word
- zero counts
- acknowledgement stalls
- a second start that arrives in the middle of a transfer

// File: rtl/dma_phase_splitter_pkg.sv
package dma_phase_splitter_pkg;
  typedef enum logic {
    SPL_IDLE = 1'b0,
    SPL_RUN  = 1'b1
  } spl_state_e;
endpackage

// File: rtl/dma_split_align.sv
module dma_split_align #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 3
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_aligned,
  output logic [OFF_W-1:0]  addr_off
);
  // Clear the lane bits to get the word address; keep them as the offset.
  assign addr_aligned = {addr_in[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign addr_off     = addr_in[OFF_W-1:0];
endmodule

// File: rtl/dma_split_lanes.sv
module dma_split_lanes #(
  parameter int BYTES = 8,
  parameter int OFF_W = 3,
  parameter int CNT_W = 16,
  parameter int NW    = OFF_W + 1
) (
  input  logic [OFF_W-1:0] lane_off,
  input  logic [CNT_W-1:0] avail,
  output logic [BYTES-1:0] lane_mask,
  output logic [NW-1:0]    nbytes
);
  logic [NW-1:0] gap;
  logic [NW-1:0] off_x;
  logic [NW-1:0] stop_x;

  assign off_x = {1'b0, lane_off};
  // Bytes left before the next boundary.
  assign gap = NW'(BYTES) - off_x;
  // This phase moves whichever is smaller: the gap or the bytes still left.
  assign nbytes = (avail < CNT_W'(gap)) ? avail[NW-1:0] : gap;
  assign stop_x = off_x + nbytes;

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign lane_mask[i] = (off_x <= NW'(i)) && (NW'(i) < stop_x);
  end
endmodule

// File: rtl/dma_phase_splitter.sv
module dma_phase_splitter #(
  parameter int BUS_W  = 64,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic [CNT_W-1:0]     byte_cnt,
  input  logic                 phase_ack,
  output logic                 phase_valid,
  output logic [ADDR_W-1:0]    phase_addr,
  output logic [BUS_W/8-1:0]   phase_be_n,
  output logic                 phase_last,
  output logic                 done
);
  import dma_phase_splitter_pkg::*;

  localparam int BYTES = BUS_W / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam int NW    = OFF_W + 1;

  spl_state_e        state_q;
  logic [CNT_W-1:0]  rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTES-1:0]  be_q;
  logic              valid_q, last_q, done_q;

  logic [ADDR_W-1:0] start_aligned;
  logic [OFF_W-1:0]  start_off;
  logic [OFF_W-1:0]  sel_off;
  logic [CNT_W-1:0]  sel_cnt;
  logic [BYTES-1:0]  mask;
  logic [NW-1:0]     nb;
  logic [CNT_W-1:0]  rem_next;
  logic              idle;

  dma_split_align #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_align (
    .addr_in      (start_addr),
    .addr_aligned (start_aligned),
    .addr_off     (start_off)
  );

  // When idle, size the first phase from the request; while running, size the
  // next phase from the bytes that remain after the current one.
  assign idle    = (state_q == SPL_IDLE);
  assign sel_off = idle ? start_off : '0;
  assign sel_cnt = idle ? byte_cnt : rem_q;

  dma_split_lanes #(.BYTES(BYTES), .OFF_W(OFF_W), .CNT_W(CNT_W), .NW(NW)) u_lanes (
    .lane_off  (sel_off),
    .avail     (sel_cnt),
    .lane_mask (mask),
    .nbytes    (nb)
  );

  assign rem_next = sel_cnt - CNT_W'(nb);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SPL_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      be_q    <= '1;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SPL_IDLE: begin
          if (start) begin
            if (byte_cnt == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= SPL_RUN;
              valid_q <= 1'b1;
              addr_q  <= start_aligned;
              be_q    <= ~mask;
              rem_q   <= rem_next;
              last_q  <= (rem_next == '0);
            end
          end
        end
        default: begin
          if (phase_ack) begin
            if (last_q) begin
              state_q <= SPL_IDLE;
              valid_q <= 1'b0;
              last_q  <= 1'b0;
              be_q    <= '1;
              done_q  <= 1'b1;
            end else begin
              addr_q <= addr_q + ADDR_W'(BYTES);
              be_q   <= ~mask;
              rem_q  <= rem_next;
              last_q <= (rem_next == '0);
            end
          end
        end
      endcase
    end
  end

  assign phase_valid = valid_q;
  assign phase_addr  = addr_q;
  assign phase_be_n  = be_q;
  assign phase_last  = last_q;
  assign done        = done_q;
endmodule

// File: rtl/dma_phase_splitter_chk.sv
module dma_phase_splitter_chk #(
  parameter int BUS_W  = 64,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [CNT_W-1:0]   byte_cnt,
  input logic               phase_ack,
  input logic               phase_valid,
  input logic [ADDR_W-1:0]  phase_addr,
  input logic [BUS_W/8-1:0] phase_be_n,
  input logic               phase_last,
  input logic               done
);
  localparam int BYTES = BUS_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  // R7
  addr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    phase_valid |-> (phase_addr[OFF_W-1:0] == '0));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_valid && phase_ack && !phase_last) |=>
      (phase_valid && phase_addr == $past(phase_addr) + ADDR_W'(BYTES)));

  // R2
  some_lane_chk: assert property (@(posedge clk) disable iff (rst)
    phase_valid |-> ($countones(~phase_be_n) >= 1));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_valid && !phase_ack) |=>
      (phase_valid && $stable(phase_addr) && $stable(phase_be_n) && $stable(phase_last)));

  // R6
  zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !phase_valid && byte_cnt == '0) |=> (done && !phase_valid));

  // R9
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_valid && phase_ack && phase_last) |=> (done && !phase_valid));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !phase_valid && byte_cnt != '0) |=> phase_valid);
endmodule

bind dma_phase_splitter dma_phase_splitter_chk #(
  .BUS_W(BUS_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .byte_cnt(byte_cnt),
  .phase_ack(phase_ack), .phase_valid(phase_valid), .phase_addr(phase_addr),
  .phase_be_n(phase_be_n), .phase_last(phase_last), .done(done)
);

// File: tb/dma_phase_splitter_test.sv
module dma_phase_splitter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        start64 = 1'b0, start32 = 1'b0;
  logic [31:0] s_addr = '0;
  logic [15:0] s_cnt = '0;
  logic        ack = 1'b0;
  logic        sel64 = 1'b1;
  logic        ack64, ack32;

  logic        v64, l64, d64, v32, l32, d32;
  logic [31:0] a64, a32;
  logic [7:0]  be64;
  logic [3:0]  be32;

  logic        ov, ol, od;
  logic [31:0] oa;
  logic [7:0]  obe;

  int checks = 0;
  int fails  = 0;

  assign ack64 = ack & sel64;
  assign ack32 = ack & ~sel64;

  dma_phase_splitter #(.BUS_W(64), .ADDR_W(32), .CNT_W(16)) uut (
    .clk(clk), .rst(rst), .start(start64), .start_addr(s_addr), .byte_cnt(s_cnt),
    .phase_ack(ack64), .phase_valid(v64), .phase_addr(a64), .phase_be_n(be64),
    .phase_last(l64), .done(d64)
  );

  dma_phase_splitter #(.BUS_W(32), .ADDR_W(32), .CNT_W(16)) uut32 (
    .clk(clk), .rst(rst), .start(start32), .start_addr(s_addr), .byte_cnt(s_cnt),
    .phase_ack(ack32), .phase_valid(v32), .phase_addr(a32), .phase_be_n(be32),
    .phase_last(l32), .done(d32)
  );

  always_comb begin
    if (sel64) begin
      ov = v64; oa = a64; obe = be64; ol = l64; od = d64;
    end else begin
      ov = v32; oa = a32; obe = {4'hF, be32}; ol = l32; od = d32;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [31:0] addr, input int cnt);
    s_addr = addr;
    s_cnt  = 16'(cnt);
    if (sel64) start64 = 1'b1; else start32 = 1'b1;
    @(negedge clk);
    start64 = 1'b0;
    start32 = 1'b0;
  endtask

  task automatic check_phase(input logic [31:0] ea, input logic [7:0] ebe, input bit el,
                             input string tag);
    chk(ov == 1'b1, tag, 64'(ov), 64'd1);
    chk(oa == ea, "R7", 64'(oa), 64'(ea));
    chk(obe == ebe, tag, 64'(obe), 64'(ebe));
    chk(ol == el, "R4", 64'(ol), 64'(el));
  endtask

  // One whole transfer with the expected phases computed from the requirements.
  task automatic run_xfer(input bit is64, input logic [31:0] addr, input int cnt,
                          input int stall, input bit poke);
    int b, off, rem, n;
    logic [31:0] a;
    logic [7:0] mask, ebe;
    bit first, el;
    string tag;
    @(negedge clk);
    sel64 = is64;
    b = is64 ? 8 : 4;
    pulse_start(addr, cnt);
    if (cnt == 0) begin
      chk(od == 1'b1, "R6", 64'(od), 64'd1);
      chk(ov == 1'b0, "R6", 64'(ov), 64'd0);
      @(negedge clk);
      chk(od == 1'b0, "R9", 64'(od), 64'd0);
      return;
    end
    chk(ov == 1'b1, "R11", 64'(ov), 64'd1);
    off = int'(addr) % b;
    rem = cnt;
    a = addr & ~(32'(b) - 32'd1);
    first = 1'b1;
    while (rem > 0) begin
      n = (b - off < rem) ? (b - off) : rem;
      mask = '0;
      for (int i = 0; i < 8; i++) if (i >= off && i < off + n) mask[i] = 1'b1;
      ebe = ~mask;
      el = (rem == n);
      if (first && el) tag = "R5";
      else if (first) tag = "R2";
      else if (el) tag = "R4";
      else tag = "R3";
      check_phase(a, ebe, el, tag);
      if (first) begin
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          check_phase(a, ebe, el, "R8");
        end
        if (poke) begin
          pulse_start(32'h0000_0F00, 40);
          check_phase(a, ebe, el, "R10");
        end
      end
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      rem -= n;
      a += 32'(b);
      off = 0;
      first = 1'b0;
    end
    chk(ov == 1'b0, "R9", 64'(ov), 64'd0);
    chk(od == 1'b1, "R9", 64'(od), 64'd1);
    @(negedge clk);
    chk(od == 1'b0, "R9", 64'(od), 64'd0);
    chk(ov == 1'b0, "R10", 64'(ov), 64'd0);
  endtask

  task automatic test_reset();
    // R1
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(v64 == 1'b0 && d64 == 1'b0 && l64 == 1'b0, "R1", {61'd0, v64, d64, l64}, 64'd0);
    chk(be64 == 8'hFF, "R1", 64'(be64), 64'hFF);
    chk(v32 == 1'b0 && d32 == 1'b0 && l32 == 1'b0, "R1", {61'd0, v32, d32, l32}, 64'd0);
    chk(be32 == 4'hF, "R1", 64'(be32), 64'hF);
  endtask

  task automatic test_unaligned64();   run_xfer(1'b1, 32'h0000_1003, 20, 0, 1'b0); endtask
  task automatic test_aligned64();     run_xfer(1'b1, 32'h0000_2000, 16, 0, 1'b0); endtask
  task automatic test_inside_word64(); run_xfer(1'b1, 32'h0000_3005, 2, 0, 1'b0);  endtask
  task automatic test_fill_gap64();    run_xfer(1'b1, 32'h0000_4006, 2, 0, 1'b0);  endtask
  task automatic test_zero64();        run_xfer(1'b1, 32'h0000_0010, 0, 0, 1'b0);  endtask
  task automatic test_stall_poke64();  run_xfer(1'b1, 32'h0000_5001, 12, 3, 1'b1); endtask
  task automatic test_unaligned32();   run_xfer(1'b0, 32'h0000_0101, 9, 0, 1'b0);  endtask
  task automatic test_single32();      run_xfer(1'b0, 32'h0000_0302, 1, 0, 1'b0);  endtask
  task automatic test_zero32();        run_xfer(1'b0, 32'h0000_0200, 0, 0, 1'b0);  endtask
  task automatic test_stall_poke32();  run_xfer(1'b0, 32'h0000_0603, 6, 2, 1'b1);  endtask

  initial begin
    test_reset();
    test_unaligned64();
    test_aligned64();
    test_inside_word64();
    test_fill_gap64();
    test_zero64();
    test_stall_poke64();
    test_unaligned32();
    test_single32();
    test_zero32();
    test_stall_poke32();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule